// File: doc/BRIEF.md
# UART Receive Error Controller

This block sits behind the receive shifter of a simple UART receiver that has no FIFO. For every completed character the shifter gives it a one-cycle frame-done pulse, the character, and its parity and framing error qualifiers. A break is reported on a separate one-cycle pulse. The block does four things:

- It holds the received byte and a data-ready flag.
- It detects overrun itself, when a new character arrives before software has read the previous one.
- It keeps sticky error flags and a summary flag that is the OR of those error flags.
- It drives two interrupt requests: one for received data or break, and one for errors.

Parity, framing and overrun errors are recorded, but reception goes on. A break locks the receiver: every later character is dropped until a software reset or a system reset. The software reset is a level input. While it is high, all flags stay clear and no frame is accepted.

Top module: `uart_rx_err_ctrl`

## Requirements
- R1: After the system reset is released, `status` reads 0x00 and both `rx_irq` and `err_irq` are low.
- R2: An accepted frame loads `frm_data` into `rx_data` and sets the ready bit (`status` bit 6) on the clock edge that samples `frm_done`. A `rd_strobe` with no frame in the same cycle clears the ready bit on the next edge.
- R3: The parity error bit (`status` bit 2) and the framing error bit (`status` bit 4) set on the same edge as an accepted frame that carries `par_err` or `frm_err`. A later clean frame does not clear them.
- R4: The overrun bit (`status` bit 3) sets when a frame is accepted while the ready bit is set and `rd_strobe` is low. The new byte replaces the old one in `rx_data`.
- R5: The summary bit (`status` bit 7) is the OR of status bits 5 down to 2. Bits 1 and 0 always read 0.
- R6: A `brk_det` pulse sets the break bit (`status` bit 5). From then on, any frame (including one that coincides with the pulse) is dropped: `rx_data` and the ready bit do not change. Reception resumes after a software reset.
- R7: After a parity, framing or overrun error, later frames are still accepted and delivered to `rx_data`.
- R8: `err_irq` is high exactly when the summary bit and `err_irq_en` are both set.
- R9: `rx_irq` is high when the ready bit and `rx_irq_en` are both set, or when the break bit and `brk_irq_en` are both set. `err_irq_en` has no effect on `rx_irq`.
- R10: While `sw_rst` is high, every status bit is held at 0 and frames are not accepted. If `sw_rst` coincides with a flag-setting event, the reset wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside the block |
| sw_rst | input | 1 | Level-active software reset of the receive state |
| frm_done | input | 1 | One-cycle pulse: a character has been completed |
| frm_data | input | DATA_W | Character that comes with `frm_done` |
| par_err | input | 1 | Parity error qualifier for `frm_done` |
| frm_err | input | 1 | Framing error qualifier for `frm_done` |
| brk_det | input | 1 | One-cycle pulse: a break has been detected |
| rd_strobe | input | 1 | Software read of the data register; clears the ready bit |
| rx_irq_en | input | 1 | Enables the data-ready interrupt |
| err_irq_en | input | 1 | Enables the error interrupt |
| brk_irq_en | input | 1 | Enables the break interrupt on `rx_irq` |
| rx_data | output | DATA_W | Last accepted character |
| status | output | 8 | {summary, ready, break, framing, overrun, parity, 2'b00} |
| rx_irq | output | 1 | Receive/break interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
The bench tries the main function with five input patterns:

- A clean frame, which separates data delivery from error recording.
- A parity-error frame followed by a clean frame, which shows whether error flags are sticky and whether reception continues.
- A framing-error frame, which shows the framing bit is distinct from the parity bit.
- Two frames with no read between them, which isolates overrun and shows the new byte replacing the old one.
- A break pulse followed by more frames, which shows the lockout and its release by software reset.

Each pattern is run with the interrupt enables in different settings, so that the break path on `rx_irq` can be told apart from the error path on `err_irq`. A software reset that coincides with an erroneous frame shows which event has priority.

// File: rtl/uart_rxe_pkg.sv
package uart_rxe_pkg;
  localparam int STAT_W  = 8;
  localparam int BIT_PE  = 2;
  localparam int BIT_OE  = 3;
  localparam int BIT_FE  = 4;
  localparam int BIT_BRK = 5;
  localparam int BIT_RDY = 6;
  localparam int BIT_SUM = 7;
  localparam int N_ERR   = 4;

  // Packed so that bit i lines up with status bit BIT_PE + i.
  typedef struct packed {
    logic brk;
    logic fe;
    logic oe;
    logic pe;
  } err_flags_t;
endpackage

// File: rtl/rxe_data_buf.sv
module rxe_data_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] data_q,
  output logic              ready_q,
  output logic              ovr_evt
);
  logic [DATA_W-1:0] data_d;
  logic              ready_d;
  logic              data_en;

  // A frame is an overrun when it lands on unread data.
  assign ovr_evt = accept & ready_q & ~rd_strobe;
  assign data_en = accept;

  always_comb begin
    data_d  = data_q;
    ready_d = ready_q;
    if (data_en)
      data_d = frm_data;
    if (sw_rst)
      ready_d = 1'b0;
    else if (accept)
      ready_d = 1'b1;
    else if (rd_strobe)
      ready_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      ready_q <= ready_d;
    end
  end
endmodule

// File: rtl/rxe_flag_bank.sv
module rxe_flag_bank
  import uart_rxe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_rst,
  input  logic       accept,
  input  logic       par_err,
  input  logic       frm_err,
  input  logic       ovr_evt,
  input  logic       brk_det,
  output err_flags_t flags_q
);
  logic [N_ERR-1:0] set_vec;
  logic [N_ERR-1:0] cur_vec;
  logic [N_ERR-1:0] nxt_vec;

  assign set_vec = {brk_det, accept & frm_err, ovr_evt, accept & par_err};
  assign cur_vec = flags_q;

  // One sticky bit per error source; software reset wins over a set.
  for (genvar i = 0; i < N_ERR; i++) begin : g_flag
    always_comb begin
      if (sw_rst)
        nxt_vec[i] = 1'b0;
      else
        nxt_vec[i] = cur_vec[i] | set_vec[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags_q <= '0;
    else
      flags_q <= err_flags_t'(nxt_vec);
  end
endmodule

// File: rtl/rxe_irq_gate.sv
module rxe_irq_gate
  import uart_rxe_pkg::*;
(
  input  err_flags_t flags,
  input  logic       ready,
  input  logic       rx_irq_en,
  input  logic       err_irq_en,
  input  logic       brk_irq_en,
  output logic       summary,
  output logic       rx_irq,
  output logic       err_irq
);
  always_comb begin
    summary = |flags;
    err_irq = summary & err_irq_en;
    rx_irq  = (ready & rx_irq_en) | (flags.brk & brk_irq_en);
  end
endmodule

// File: rtl/uart_rx_err_ctrl.sv
module uart_rx_err_ctrl
  import uart_rxe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              frm_done,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              par_err,
  input  logic              frm_err,
  input  logic              brk_det,
  input  logic              rd_strobe,
  input  logic              rx_irq_en,
  input  logic              err_irq_en,
  input  logic              brk_irq_en,
  output logic [DATA_W-1:0] rx_data,
  output logic [STAT_W-1:0] status,
  output logic              rx_irq,
  output logic              err_irq
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       accept;
  logic       ready;
  logic       ovr_evt;
  logic       summary;
  err_flags_t flags;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // The frame that carries a break, and every frame after it, is dropped.
  assign accept = frm_done & ~sw_rst & ~flags.brk & ~brk_det;

  rxe_data_buf #(.DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .sw_rst    (sw_rst),
    .accept    (accept),
    .frm_data  (frm_data),
    .rd_strobe (rd_strobe),
    .data_q    (rx_data),
    .ready_q   (ready),
    .ovr_evt   (ovr_evt)
  );

  rxe_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .sw_rst  (sw_rst),
    .accept  (accept),
    .par_err (par_err),
    .frm_err (frm_err),
    .ovr_evt (ovr_evt),
    .brk_det (brk_det),
    .flags_q (flags)
  );

  rxe_irq_gate u_irq (
    .flags      (flags),
    .ready      (ready),
    .rx_irq_en  (rx_irq_en),
    .err_irq_en (err_irq_en),
    .brk_irq_en (brk_irq_en),
    .summary    (summary),
    .rx_irq     (rx_irq),
    .err_irq    (err_irq)
  );

  always_comb begin
    status          = '0;
    status[BIT_SUM] = summary;
    status[BIT_RDY] = ready;
    status[BIT_BRK] = flags.brk;
    status[BIT_FE]  = flags.fe;
    status[BIT_OE]  = flags.oe;
    status[BIT_PE]  = flags.pe;
  end
endmodule

// File: rtl/rxe_checker.sv
module rxe_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_rst,
  input logic              frm_done,
  input logic              brk_det,
  input logic              rd_strobe,
  input logic              err_irq_en,
  input logic [DATA_W-1:0] rx_data,
  input logic [7:0]        status,
  input logic              err_irq
);
  p_swrst_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (status == 8'h00));

  p_parity_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && !sw_rst) |=> status[2]);

  p_break_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && frm_done) |=> $stable(rx_data));

  p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && status[6] && !rd_strobe && !status[5] && !brk_det && !sw_rst) |=> status[3]);

  p_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] == (|status[5:2])) && (status[1:0] == 2'b00));

  p_err_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (err_irq_en && status[7]));
endmodule

bind uart_rx_err_ctrl rxe_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_rst     (sw_rst),
  .frm_done   (frm_done),
  .brk_det    (brk_det),
  .rd_strobe  (rd_strobe),
  .err_irq_en (err_irq_en),
  .rx_data    (rx_data),
  .status     (status),
  .err_irq    (err_irq)
);

// File: tb/sim_uart_rx_err_ctrl.sv
module sim_uart_rx_err_ctrl;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sw_rst = 1'b0;
  logic          frm_done = 1'b0;
  logic [DW-1:0] frm_data = '0;
  logic          par_err = 1'b0;
  logic          frm_err = 1'b0;
  logic          brk_det = 1'b0;
  logic          rd_strobe = 1'b0;
  logic          rx_irq_en = 1'b0;
  logic          err_irq_en = 1'b0;
  logic          brk_irq_en = 1'b0;
  logic [DW-1:0] rx_data;
  logic [7:0]    status;
  logic          rx_irq;
  logic          err_irq;

  int n_run = 0;
  int n_fail = 0;
  logic [DW-1:0] held;

  always #4 clk = ~clk;

  uart_rx_err_ctrl #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .frm_done(frm_done),
    .frm_data(frm_data), .par_err(par_err), .frm_err(frm_err),
    .brk_det(brk_det), .rd_strobe(rd_strobe), .rx_irq_en(rx_irq_en),
    .err_irq_en(err_irq_en), .brk_irq_en(brk_irq_en), .rx_data(rx_data),
    .status(status), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Inputs change on the falling edge; results are read one falling edge later.
  task automatic send(input logic [DW-1:0] d, input logic pe, input logic fe, input logic rd);
    @(negedge clk);
    frm_done = 1'b1; frm_data = d; par_err = pe; frm_err = fe; rd_strobe = rd;
    @(negedge clk);
    frm_done = 1'b0; par_err = 1'b0; frm_err = 1'b0; rd_strobe = 1'b0;
  endtask

  task automatic read_data();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic soft_reset();
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h00);
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 err_irq", err_irq, 0);
  endtask

  task automatic t_clean();
    rx_irq_en = 1'b1;
    send(8'h5A, 1'b0, 1'b0, 1'b0);
    chk("R2 status", status, 8'h40);
    chk("R2 data", rx_data, 8'h5A);
    chk("R9 rx_irq ready", rx_irq, 1);
    read_data();
    chk("R2 read clears ready", status, 8'h00);
    chk("R9 rx_irq idle", rx_irq, 0);
    rx_irq_en = 1'b0;
  endtask

  task automatic t_parity_then_clean();
    send(8'h11, 1'b1, 1'b0, 1'b0);
    chk("R3 R5 parity status", status, 8'hC4);
    read_data();
    send(8'h22, 1'b0, 1'b0, 1'b0);
    chk("R7 delivered after parity", rx_data, 8'h22);
    chk("R3 parity sticky", status, 8'hC4);
    chk("R8 err_irq disabled", err_irq, 0);
    @(negedge clk); err_irq_en = 1'b1; #1;
    chk("R8 err_irq enabled", err_irq, 1);
    read_data();
    soft_reset();
    chk("R10 soft reset clears", status, 8'h00);
    chk("R8 err_irq after clear", err_irq, 0);
    err_irq_en = 1'b0;
  endtask

  task automatic t_framing();
    send(8'h33, 1'b0, 1'b1, 1'b0);
    chk("R3 framing status", status, 8'hD0);
    read_data();
    soft_reset();
  endtask

  task automatic t_overrun();
    send(8'h44, 1'b0, 1'b0, 1'b0);
    send(8'h55, 1'b0, 1'b0, 1'b0);
    chk("R4 overrun status", status, 8'hC8);
    chk("R4 new byte kept", rx_data, 8'h55);
    send(8'h66, 1'b0, 1'b0, 1'b0);
    chk("R7 delivered after overrun", rx_data, 8'h66);
    read_data();
    soft_reset();
  endtask

  task automatic t_break();
    brk_irq_en = 1'b1;
    held = rx_data;
    @(negedge clk); brk_det = 1'b1;
    @(negedge clk); brk_det = 1'b0;
    chk("R6 break status", status, 8'hA0);
    chk("R9 break irq with err_en low", rx_irq, 1);
    chk("R8 no err_irq", err_irq, 0);
    send(8'h77, 1'b0, 1'b0, 1'b0);
    chk("R6 frame dropped data", rx_data, held);
    chk("R6 frame dropped status", status, 8'hA0);
    @(negedge clk); brk_irq_en = 1'b0; #1;
    chk("R9 break irq disabled", rx_irq, 0);
    soft_reset();
    chk("R10 break cleared", status, 8'h00);
    send(8'h88, 1'b0, 1'b0, 1'b0);
    chk("R6 resumes after soft reset", rx_data, 8'h88);
    chk("R6 resume status", status, 8'h40);
    read_data();
  endtask

  task automatic t_collision();
    held = rx_data;
    @(negedge clk);
    sw_rst = 1'b1; frm_done = 1'b1; frm_data = 8'h99; par_err = 1'b1;
    @(negedge clk);
    chk("R10 reset wins status", status, 8'h00);
    chk("R10 frame refused", rx_data, held);
    frm_done = 1'b0; par_err = 1'b0; sw_rst = 1'b0;
    @(negedge clk);
    chk("R10 after release", status, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clean();
    t_parity_then_clean();
    t_framing();
    t_overrun();
    t_break();
    t_collision();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule